// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synchronous single-port static memory. It accepts one command on every clock edge. The data phase of every command comes exactly two edges later, for reads and for writes alike. Because of this fixed delay, a read may directly follow a write, and a write may directly follow a read, with no idle cycle on the shared data bus. The bus is modelled as three ports: a data input, a data output and an output enable.

A command is either a load or an advance. A load takes an external address and a direction. An advance steps a small linear burst counter and keeps the direction chosen at the load. Three chip enables qualify a load. An active-low clock enable can freeze the whole block for any cycle. Writes are done per byte lane, using strobes that travel down the pipeline together with their command.

The storage holds 2^STORE_AW words. It is indexed by the low address bits, so higher address bits alias onto the same words.

Top module: `zbt_sram`

## Requirements
- R1: A load cycle (adv_ld low) with sel1_n low, sel2 high and sel3_n low is a selected cycle. If any one of the three enables is inactive, the cycle is a deselect.
- R2: In a selected load, the address is taken from the addr port. rw high starts a read and rw low starts a write. The storage word used is addr[STORE_AW-1:0].
- R3: When adv_ld is high after a selected load, the address steps bits [1:0] up by one, wrapping 3 to 0, while bits [17:2] stay fixed. rw is ignored in that cycle, and the direction latched at the load is kept.
- R4: For a read command sampled at edge k, dq_out carries the stored word and dq_oe is high after edge k+2. For a write command sampled at edge k, dq_in is captured at edge k+2. This counts only unsuspended edges.
- R5: A deselect command gives dq_oe low after its data-phase edge. An advance that follows a deselect is also idle and drives nothing.
- R6: An edge with cen_n high is suppressed. The pipeline, the burst state, the storage, dq_out and dq_oe all keep their values.
- R7: bw_n[i] low writes lane i, which is bits [9i+8:9i]. Any set of lanes may be written in one cycle. A write with bw_n equal to 2'b11 changes nothing. dq_oe is never high in the data phase of a write.
- R8: The synchronous active-high rst clears both pipeline stages and the burst state, and holds dq_oe low.
- R9: A read issued in the cycle right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low; high suspends the edge |
| sel1_n | input | 1 | Chip enable, active low |
| sel2 | input | 1 | Chip enable, active high |
| sel3_n | input | 1 | Chip enable, active low |
| rw | input | 1 | Direction at load: 1 read, 0 write |
| adv_ld | input | 1 | 0 load external address, 1 advance burst |
| bw_n | input | 2 | Byte-lane write strobes, active low |
| addr | input | 18 | External address |
| dq_in | input | 18 | Bus data into the block |
| dq_out | output | 18 | Bus data out of the block |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is a suspended edge that falls inside a burst. In that case one command has been decoded but not yet used, and a data phase is waiting two stages down. The output must freeze, and the following edges must then resume the burst with the right address and direction. The bench reaches this in a directed sequence: a read burst whose start address wraps, with cen_n held high between advances. It also drives about a tenth of the random cycles suspended, mixed with bursts, deselects and partial-lane writes. A reference model checks every cycle, and that model applies the suspend rule on its own.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    localparam int ADDR_W  = 18;
    localparam int LANES   = 2;
    localparam int LANE_W  = 9;
    localparam int DATA_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    localparam logic [BURST_W-1:0] BURST_ONE = {{(BURST_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic              valid;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lane_we;
    } cmd_t;

    localparam cmd_t CMD_IDLE = '0;

    function automatic logic [ADDR_W-1:0] burst_step(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:BURST_W], a[BURST_W-1:0] + BURST_ONE};
    endfunction
endpackage

// File: rtl/zbt_cmd_decode.sv
module zbt_cmd_decode
    import zbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              sel_ok,
    input  logic              adv,
    input  logic              rd_req,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              cmd
);
    logic              active_q;
    logic              dir_q;
    logic [ADDR_W-1:0] cur_q;

    always_comb begin
        cmd = CMD_IDLE;
        if (!adv) begin
            if (sel_ok) begin
                cmd.valid   = 1'b1;
                cmd.rd      = rd_req;
                cmd.addr    = addr;
                cmd.lane_we = ~bw_n;
            end
        end else if (active_q) begin
            cmd.valid   = 1'b1;
            cmd.rd      = dir_q;
            cmd.addr    = burst_step(cur_q);
            cmd.lane_we = ~bw_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            dir_q    <= 1'b0;
            cur_q    <= '0;
        end else if (ce) begin
            if (!adv) begin
                active_q <= sel_ok;
                dir_q    <= rd_req;
                cur_q    <= addr;
            end else if (active_q) begin
                cur_q <= burst_step(cur_q);
            end
        end
    end

    // R3: upper bits fixed, low bits step by one with wrap
    assert_burst_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        ce && adv && active_q |=>
            (cur_q[ADDR_W-1:BURST_W] == $past(cur_q[ADDR_W-1:BURST_W])) &&
            (cur_q[BURST_W-1:0] == ($past(cur_q[BURST_W-1:0]) + BURST_ONE)));

    // R3: direction is not changed by an advance
    assert_burst_dir_R3: assert property (@(posedge clk) disable iff (rst)
        ce && adv |=> $stable(dir_q));
endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe
    import zbt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  cmd_t cmd_in,
    output cmd_t cmd_out
);
    cmd_t stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)     stage_q[i] <= CMD_IDLE;
                else if (ce) stage_q[i] <= cmd_in;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)     stage_q[i] <= CMD_IDLE;
                else if (ce) stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign cmd_out = stage_q[STAGES-1];
endmodule

// File: rtl/zbt_store.sv
module zbt_store
    import zbt_pkg::*;
#(
    parameter int STORE_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int DEPTH = 1 << STORE_AW;

    logic [STORE_AW-1:0] idx;
    assign idx = cmd.addr[STORE_AW-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q_lane;

        always_ff @(posedge clk) begin
            if (ce && cmd.valid && !cmd.rd && cmd.lane_we[g])
                mem[idx] <= dq_in[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst)                         q_lane <= '0;
            else if (ce && cmd.valid && cmd.rd) q_lane <= mem[idx];
        end

        assign dq_out[g*LANE_W +: LANE_W] = q_lane;
    end

    always_ff @(posedge clk) begin
        if (rst)     dq_oe <= 1'b0;
        else if (ce) dq_oe <= cmd.valid && cmd.rd;
    end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int STORE_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              rw,
    input  logic              adv_ld,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int PIPE_STAGES = 2;

    logic ce;
    logic sel_ok;
    cmd_t cmd_dec;
    cmd_t cmd_phase;

    assign ce     = !cen_n;
    assign sel_ok = !sel1_n && sel2 && !sel3_n;

    zbt_cmd_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .sel_ok (sel_ok),
        .adv    (adv_ld),
        .rd_req (rw),
        .bw_n   (bw_n),
        .addr   (addr),
        .cmd    (cmd_dec)
    );

    zbt_pipe #(.STAGES(PIPE_STAGES)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .cmd_in  (cmd_dec),
        .cmd_out (cmd_phase)
    );

    zbt_store #(.STORE_AW(STORE_AW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .cmd    (cmd_phase),
        .dq_in  (dq_in),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    // R4: a decoded read drives the bus after its third unsuspended edge
    assert_read_drives_R4: assert property (@(posedge clk) disable iff (rst)
        ce && cmd_dec.valid && cmd_dec.rd ##1 ce ##1 ce |=> dq_oe);

    // R5: a deselect or idle advance leaves the bus undriven
    assert_deselect_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        ce && !cmd_dec.valid ##1 ce ##1 ce |=> !dq_oe);

    // R7: a write data phase never drives the bus
    assert_write_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        ce && cmd_dec.valid && !cmd_dec.rd ##1 ce ##1 ce |=> !dq_oe);

    // R6: a suspended edge freezes the outputs
    assert_suspend_hold_R6: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> $stable(dq_oe) && $stable(dq_out));

    // R8: reset leaves the bus undriven
    assert_reset_idle_R8: assert property (@(posedge clk)
        rst |=> !dq_oe);
endmodule

// File: tb/zbt_sram_tb_top.sv
module zbt_sram_tb_top;
    localparam int SAW = 10;
    localparam int NW  = 1 << SAW;

    logic        clk = 1'b0;
    logic        rst, cen_n, sel1_n, sel2, sel3_n, rw, adv_ld;
    logic [1:0]  bw_n;
    logic [17:0] addr, dq_in, dq_out;
    logic        dq_oe;

    always #2 clk = ~clk;

    zbt_sram #(.STORE_AW(SAW)) dut_i (
        .clk(clk), .rst(rst), .cen_n(cen_n), .sel1_n(sel1_n), .sel2(sel2),
        .sel3_n(sel3_n), .rw(rw), .adv_ld(adv_ld), .bw_n(bw_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct packed {
        bit        v;
        bit        rd;
        bit [17:0] a;
        bit [1:0]  we;
        int        tag;
    } mcmd_t;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string phase_tag = "";

    mcmd_t     s1, s2;
    bit        m_act, m_dir;
    bit [17:0] m_cur;
    bit [8:0]  mem   [2][NW];
    bit        known [2][NW];
    bit        exp_oe;
    bit [17:0] exp_q;
    bit [1:0]  exp_known;
    int        exp_tag;

    function automatic string tname(input int c);
        case (c)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic mcmd_t idle_cmd(input int t);
        mcmd_t c;
        c = '0;
        c.tag = t;
        return c;
    endfunction

    task automatic model_reset();
        s1 = idle_cmd(8); s2 = idle_cmd(8);
        m_act = 0; m_dir = 0; m_cur = '0;
        exp_oe = 0; exp_tag = 8;
    endtask

    // One edge of the model, using the inputs just driven
    task automatic model_edge();
        mcmd_t n;
        bit    sel;
        int    idx;
        if (cen_n) begin
            exp_tag = 6;
            return;
        end
        exp_tag = s2.tag;
        idx = int'(s2.a[SAW-1:0]);
        exp_oe = 0;
        if (s2.v && s2.rd) begin
            exp_oe = 1;
            exp_q  = {mem[1][idx], mem[0][idx]};
            exp_known = {known[1][idx], known[0][idx]};
        end else if (s2.v) begin
            if (s2.we == 2'b00) exp_tag = 7;
            for (int l = 0; l < 2; l++)
                if (s2.we[l]) begin
                    mem[l][idx]   = dq_in[l*9 +: 9];
                    known[l][idx] = 1;
                end
        end
        sel = !sel1_n && sel2 && !sel3_n;
        if (!adv_ld) begin
            n = sel ? '{1'b1, rw, addr, ~bw_n, 2} : idle_cmd(1);
            m_act = sel; m_cur = addr; m_dir = rw;
        end else if (m_act) begin
            m_cur = {m_cur[17:2], m_cur[1:0] + 2'd1};
            n = '{1'b1, m_dir, m_cur, ~bw_n, 3};
        end else begin
            n = idle_cmd(5);
        end
        s2 = s1;
        s1 = n;
    endtask

    task automatic check_outputs();
        total++;
        if (dq_oe !== exp_oe) begin
            bad++;
            $display("FAIL %s %s dq_oe actual=%b expected=%b", tname(exp_tag), phase_tag, dq_oe, exp_oe);
        end
        if (exp_oe) begin
            for (int l = 0; l < 2; l++) begin
                if (exp_known[l]) begin
                    total++;
                    if (dq_out[l*9 +: 9] !== exp_q[l*9 +: 9]) begin
                        bad++;
                        $display("FAIL R4 R7 %s %s lane%0d actual=%h expected=%h",
                                 tname(exp_tag), phase_tag, l, dq_out[l*9 +: 9], exp_q[l*9 +: 9]);
                    end
                end
            end
        end
    endtask

    task automatic drive(input bit c_n, input bit e1n, input bit e2, input bit e3n,
                         input bit r, input bit adv, input bit [1:0] b, input bit [17:0] a);
        cen_n = c_n; sel1_n = e1n; sel2 = e2; sel3_n = e3n;
        rw = r; adv_ld = adv; bw_n = b; addr = a;
        dq_in = 18'($urandom);
        model_edge();
        @(negedge clk);
        check_outputs();
    endtask

    task automatic load(input bit r, input bit [1:0] b, input bit [17:0] a);
        drive(0, 0, 1, 0, r, 0, b, a);
    endtask

    task automatic adv_step(input bit r, input bit [1:0] b);
        drive(0, 0, 1, 0, r, 1, b, 18'($urandom));
    endtask

    task automatic idle_step();
        drive(0, 1, 1, 0, 1, 0, 2'b11, '0);
    endtask

    function automatic bit [17:0] mk_addr(input int low);
        bit [17:0] a;
        a = 18'($urandom);
        a[SAW-1:0] = SAW'(low);
        return a;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL R4 watchdog: run actual=unfinished expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; cen_n = 0; sel1_n = 1; sel2 = 1; sel3_n = 0;
        rw = 1; adv_ld = 0; bw_n = 2'b11; addr = '0; dq_in = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        phase_tag = "R8";
        check_outputs();
        @(negedge clk);
        check_outputs();
        rst = 0;
        // R8: idle edges after reset keep the bus quiet
        idle_step(); idle_step();

        // fill words 0..63, back to back writes
        phase_tag = "fill";
        for (int i = 0; i < 64; i++) load(0, 2'b00, mk_addr(i));
        idle_step(); idle_step();

        // R3: read burst starting at low bits 2 wraps 6,7,4,5; rw toggled low is ignored
        phase_tag = "R3";
        load(1, 2'b11, mk_addr(6));
        adv_step(0, 2'b00); adv_step(0, 2'b00); adv_step(1, 2'b00);
        // R3: write burst with rw high on advances
        load(0, 2'b00, mk_addr(9));
        adv_step(1, 2'b00); adv_step(1, 2'b00); adv_step(1, 2'b00);
        load(1, 2'b11, mk_addr(8));
        adv_step(0, 2'b11); adv_step(0, 2'b11); adv_step(0, 2'b11);
        idle_step(); idle_step();

        // R6: suspend inside a read burst
        phase_tag = "R6";
        load(1, 2'b11, mk_addr(13));
        drive(1, 0, 1, 0, 0, 1, 2'b00, '0);
        adv_step(1, 2'b11);
        drive(1, 1, 0, 1, 0, 0, 2'b00, '0);
        drive(1, 1, 0, 1, 0, 0, 2'b00, '0);
        adv_step(0, 2'b11); adv_step(0, 2'b11);
        idle_step(); idle_step();

        // R1: each enable inactive in turn; R5: advance after deselect
        phase_tag = "R1";
        drive(0, 1, 1, 0, 1, 0, 2'b11, mk_addr(3));
        drive(0, 0, 0, 0, 1, 0, 2'b11, mk_addr(3));
        drive(0, 0, 1, 1, 1, 0, 2'b11, mk_addr(3));
        phase_tag = "R5";
        adv_step(1, 2'b00); adv_step(0, 2'b00);
        idle_step(); idle_step();

        // R7: lane writes and a no-write, then read back
        phase_tag = "R7";
        load(0, 2'b10, mk_addr(20));
        load(0, 2'b01, mk_addr(21));
        load(0, 2'b11, mk_addr(22));
        load(1, 2'b11, mk_addr(20));
        load(1, 2'b11, mk_addr(21));
        load(1, 2'b11, mk_addr(22));
        idle_step(); idle_step();

        // R9: read right after write, same address, with mixed turnaround
        phase_tag = "R9";
        for (int i = 0; i < 8; i++) begin
            load(0, 2'($urandom), mk_addr(30 + i));
            load(1, 2'b11, mk_addr(30 + i));
        end
        idle_step(); idle_step();

        // random mix
        phase_tag = "rand";
        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 10) == 0, ($urandom % 20) == 0, ($urandom % 20) != 0,
                  ($urandom % 20) == 0, 1'($urandom), ($urandom % 5) < 2,
                  2'($urandom), mk_addr(int'($urandom % 64)));
        end
        idle_step(); idle_step();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule